// File: doc/BRIEF.md
# Predicated Integer Execution Unit

This block is the 64-bit integer execution stage of a predicated datapath. Each cycle it may accept one operation, with two register operands, a short immediate field, a 4-bit operation code, a 2-bit shift-add count and a guard bit. One clock later it presents the result, a valid flag and a write-enable for the destination register. When the guard bit is clear, the operation is squashed. The valid flag still follows the input, but the write-enable stays low and the result register keeps its previous value.

It covers three groups of operations. The additive group is add, add with an extra one, subtract, subtract with an extra one taken off, and shift-left-by-1-to-4-then-add. The bitwise group is and, or, xor and and-with-inverted-second-operand. The shift group is left shift, arithmetic right shift and logical right shift. Immediates are sign-extended. All arithmetic wraps modulo 2^64 and sets no flags.

Top module: `pred_alu`

## Requirements
- R1: The unit has a one-cycle latency. `res_valid` is high in the cycle after an edge that sampled `in_valid` high, and low otherwise. After reset `res_valid`, `res_we` and `res_data` are 0.
- R2: Op codes 0 to 3 compute a+b, a+b+1, a-b and a-b-1, all modulo 2^64.
- R3: Op code 4 computes (a << (sa_cnt+1)) + b. `sa_cnt` is 2 bits, so the shift is 1 to 4 positions. This operation always uses both register operands and ignores `use_imm`.
- R4: Op codes 5 to 8 compute a&b, a|b, a^b and a&~b.
- R5: Op code 9 shifts a left by b. A count of 64 or more gives 0.
- R6: Op codes 10 and 11 shift a right by b, arithmetically and logically. A count of 64 or more gives 64 copies of a[63] for op 10 and 0 for op 11.
- R7: With `use_imm` set, the first operand becomes a sign-extended immediate for some operations. Add uses 14 bits (imm[13:0]), or 22 bits when `imm_wide` is 1. Subtract and the bitwise operations use 8 bits (imm[7:0]). For the shift operations, the count becomes imm[5:0] taken as unsigned, and the first operand stays the register.
- R8: An accepted operation with `qp`=0 gives `res_we`=0 and leaves `res_data` unchanged. Op codes 12 to 15 behave the same way.
- R9: An accepted operation with `qp`=1 and op code 0 to 11 gives `res_we`=1 and loads `res_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| qp | input | 1 | Qualifying predicate |
| op | input | 4 | Operation code |
| use_imm | input | 1 | Select the immediate form |
| imm_wide | input | 1 | Add immediate is 22 bits instead of 14 |
| imm | input | 22 | Raw immediate field |
| sa_cnt | input | 2 | Shift-add amount minus one |
| src_a | input | 64 | First register operand |
| src_b | input | 64 | Second register operand |
| res_valid | output | 1 | Result slot occupied |
| res_we | output | 1 | Destination write-enable |
| res_data | output | 64 | Result |

## Verification
The only state in the block is the output register, so any wrong internal value shows up on `res_data` or `res_we` one cycle after the operation that caused it. A faulty guard shows up in two ways. Either `res_we` rises for a squashed operation, or `res_data` changes when it should hold its value, and a squashed operation placed between two written ones exposes this within one cycle. Faults in the operand selection or the shifters show up as a mismatched value on the very next result. That is why the stimulus deliberately covers the extreme cases: counts of 63 and 64 or more, sign bits set, and immediates with bit 13, 21 or 7 set.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned IMMW = 22;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 4'd0,
    OP_ADD1  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUB1  = 4'd3,
    OP_SHADD = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_ANDCM = 4'd8,
    OP_SHL   = 4'd9,
    OP_SAR   = 4'd10,
    OP_SHR   = 4'd11
  } alu_op_e;

  function automatic logic op_legal(input logic [OPW-1:0] code);
    return code <= 4'd11;
  endfunction
endpackage

// File: rtl/pa_opsel.sv
module pa_opsel
  import pred_alu_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned IW = IMMW
) (
  input  logic [OPW-1:0] op,
  input  logic           use_imm,
  input  logic           imm_wide,
  input  logic [IW-1:0]  imm,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  output logic [W-1:0]   opnd_a,
  output logic [W-1:0]   opnd_b
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0] ext8, ext14, ext22, cnt_imm;

  assign ext8    = {{(W-8){imm[7]}}, imm[7:0]};
  assign ext14   = {{(W-14){imm[13]}}, imm[13:0]};
  assign ext22   = {{(W-IW){imm[IW-1]}}, imm};
  assign cnt_imm = {{(W-CW){1'b0}}, imm[CW-1:0]};

  always_comb begin
    opnd_a = src_a;
    opnd_b = src_b;
    if (use_imm) begin
      unique case (op)
        OP_ADD, OP_ADD1:                           opnd_a = imm_wide ? ext22 : ext14;
        OP_SUB, OP_SUB1, OP_AND, OP_OR, OP_XOR,
        OP_ANDCM:                                  opnd_a = ext8;
        OP_SHL, OP_SAR, OP_SHR:                    opnd_b = cnt_imm;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pa_arith.sv
module pa_arith
  import pred_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [OPW-1:0] op,
  input  logic [1:0]     sa_cnt,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sum
);
  logic [W-1:0] x, y;
  logic         cin;
  logic [2:0]   amt;

  assign amt = {1'b0, sa_cnt} + 3'd1;

  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    unique case (op)
      OP_ADD1:  cin = 1'b1;
      OP_SUB:   begin y = ~b; cin = 1'b1; end
      OP_SUB1:  y = ~b;
      OP_SHADD: x = a << amt;
      default: ;
    endcase
  end

  assign sum = x + y + {{(W-1){1'b0}}, cin};
endmodule

// File: rtl/pa_shift.sv
module pa_shift
  import pred_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   cnt,
  output logic [W-1:0]   res
);
  localparam int unsigned CW = $clog2(W);

  logic          big;
  logic [CW-1:0] sh;

  assign big = |cnt[W-1:CW];
  assign sh  = cnt[CW-1:0];

  always_comb begin
    unique case (op)
      OP_SAR:  res = big ? {W{a[W-1]}} : W'($signed(a) >>> sh);
      OP_SHR:  res = big ? '0 : a >> sh;
      default: res = big ? '0 : a << sh;
    endcase
  end
endmodule

// File: rtl/pred_alu.sv
module pred_alu
  import pred_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            qp,
  input  logic [OPW-1:0]  op,
  input  logic            use_imm,
  input  logic            imm_wide,
  input  logic [IMMW-1:0] imm,
  input  logic [1:0]      sa_cnt,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  output logic            res_valid,
  output logic            res_we,
  output logic [DW-1:0]   res_data
);
  logic [DW-1:0] opnd_a, opnd_b, sum, shres, lres, result_d;
  logic          we_d, data_en;

  pa_opsel #(.W(DW), .IW(IMMW)) u_opsel (
    .op(op), .use_imm(use_imm), .imm_wide(imm_wide), .imm(imm),
    .src_a(src_a), .src_b(src_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  pa_arith #(.W(DW)) u_arith (
    .op(op), .sa_cnt(sa_cnt), .a(opnd_a), .b(opnd_b), .sum(sum)
  );

  pa_shift #(.W(DW)) u_shift (
    .op(op), .a(opnd_a), .cnt(opnd_b), .res(shres)
  );

  always_comb begin
    unique case (op)
      OP_AND:   lres = opnd_a & opnd_b;
      OP_OR:    lres = opnd_a | opnd_b;
      OP_XOR:   lres = opnd_a ^ opnd_b;
      default:  lres = opnd_a & ~opnd_b;
    endcase
  end

  // next-state logic
  always_comb begin
    if (op <= OP_SHADD)      result_d = sum;
    else if (op <= OP_ANDCM) result_d = lres;
    else                     result_d = shres;
    we_d    = in_valid & qp & op_legal(op);
    data_en = we_d;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_we    <= 1'b0;
    end else begin
      res_valid <= in_valid;
      res_we    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_data <= '0;
    else if (data_en) res_data <= result_d;
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  a_r8_squash_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !qp) |=> !res_we);
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !qp) |=> $stable(res_data));
  a_r9_we_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_valid);
  a_r5_shl_big_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && qp && op == OP_SHL && !use_imm && src_b > 64'd63) |=> res_data == '0);
  a_r6_sar_big_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && qp && op == OP_SAR && !use_imm && src_b > 64'd63)
      |=> res_data == {DW{$past(src_a[DW-1])}});
endmodule

// File: tb/pred_alu_test.sv
module pred_alu_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, qp = 1'b0, use_imm = 1'b0, imm_wide = 1'b0;
  logic [3:0]  op = '0;
  logic [21:0] imm = '0;
  logic [1:0]  sa_cnt = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        res_valid, res_we;
  logic [63:0] res_data;

  int total = 0, bad = 0;

  typedef struct packed {
    logic        we;
    logic [63:0] data;
    logic [7:0]  req;
  } exp_t;
  exp_t sb[$];
  logic [63:0] model_hold = '0;

  pred_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .qp(qp), .op(op),
    .use_imm(use_imm), .imm_wide(imm_wide), .imm(imm), .sa_cnt(sa_cnt),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_we(res_we),
    .res_data(res_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(input logic [3:0] o, input logic ui, input logic iw,
      input logic [21:0] im, input logic [1:0] sc, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] x, y;
    x = a; y = b;
    if (ui) begin
      if (o <= 1) x = iw ? {{42{im[21]}}, im} : {{50{im[13]}}, im[13:0]};
      else if (o == 2 || o == 3 || (o >= 5 && o <= 8)) x = {{56{im[7]}}, im[7:0]};
      else if (o >= 9) y = {58'd0, im[5:0]};
    end
    case (o)
      0: return x + y;
      1: return x + y + 64'd1;
      2: return x - y;
      3: return x - y - 64'd1;
      4: return (a * (64'd1 << (sc + 1))) + b;
      5: return x & y;
      6: return x | y;
      7: return x ^ y;
      8: return x & ~y;
      9: return (y > 63) ? 64'd0 : x << y[5:0];
      10: begin
        if (y > 63) return {64{x[63]}};
        return $unsigned($signed(x) >>> y[5:0]);
      end
      default: return (y > 63) ? 64'd0 : x >> y[5:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input int rq, input logic p, input logic [3:0] o, input logic ui,
      input logic iw, input logic [21:0] im, input logic [1:0] sc,
      input logic [63:0] a, input logic [63:0] b);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; qp = p; op = o; use_imm = ui; imm_wide = iw;
    imm = im; sa_cnt = sc; src_a = a; src_b = b;
    e.we = p && (o <= 11);
    if (e.we) model_hold = model(o, ui, iw, im, sc, a, b);
    e.data = model_hold;
    e.req = 8'(rq);
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check("R1 unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check($sformatf("R%0d write-enable", e.req), {63'd0, res_we}, {63'd0, e.we});
        check($sformatf("R%0d data", e.req), res_data, e.data);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    check("watchdog", 64'd1, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, res_valid}, 64'd0);
    check("R1 reset we", {63'd0, res_we}, 64'd0);
    check("R1 reset data", res_data, 64'd0);
    rst_n = 1'b1;
    // R2 additive group, including wrap
    issue(2, 1, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    issue(2, 1, 1, 0, 0, 0, 0, 64'd10, 64'd20);
    issue(2, 1, 2, 0, 0, 0, 0, 64'd5, 64'd9);
    issue(2, 1, 3, 0, 0, 0, 0, 64'd100, 64'd1);
    // R3 shift-add, every amount; use_imm ignored
    for (int k = 0; k < 4; k++)
      issue(3, 1, 4, 0, 0, 0, 2'(k), 64'h8000_0000_0000_0003, 64'd7);
    issue(3, 1, 4, 1, 1, 22'h3FFFFF, 2'd1, 64'd3, 64'd1);
    // R4 bitwise
    issue(4, 1, 5, 0, 0, 0, 0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF);
    issue(4, 1, 6, 0, 0, 0, 0, 64'hF0F0_0000_0000_0000, 64'h000F_0000_0000_0001);
    issue(4, 1, 7, 0, 0, 0, 0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000);
    issue(4, 1, 8, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_0000);
    // R5 left shift
    issue(5, 1, 9, 0, 0, 0, 0, 64'd1, 64'd63);
    issue(5, 1, 9, 0, 0, 0, 0, 64'hFFFF, 64'd64);
    issue(5, 1, 9, 0, 0, 0, 0, 64'hFFFF, 64'h1_0000_0000);
    // R6 right shifts
    issue(6, 1, 10, 0, 0, 0, 0, 64'h8000_0000_0000_0000, 64'd4);
    issue(6, 1, 10, 0, 0, 0, 0, 64'h8000_0000_0000_0000, 64'd200);
    issue(6, 1, 10, 0, 0, 0, 0, 64'h7000_0000_0000_0000, 64'd200);
    issue(6, 1, 11, 0, 0, 0, 0, 64'h8000_0000_0000_0000, 64'd4);
    issue(6, 1, 11, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64);
    // R7 immediates
    issue(7, 1, 0, 1, 0, 22'h002000, 0, 0, 64'd0);
    issue(7, 1, 0, 1, 1, 22'h200000, 0, 0, 64'd1);
    issue(7, 1, 1, 1, 0, 22'h001FFF, 0, 0, 64'd1);
    issue(7, 1, 2, 1, 0, 22'h000080, 0, 0, 64'd1);
    issue(7, 1, 8, 1, 0, 22'h0000F0, 0, 0, 64'h30);
    issue(7, 1, 9, 1, 0, 22'h0000C4, 0, 64'd3, 64'd0);
    issue(7, 1, 10, 1, 0, 22'h00003F, 0, 64'h8000_0000_0000_0000, 64'd0);
    // R8 squash and illegal codes between writes
    issue(9, 1, 0, 0, 0, 0, 0, 64'h1234, 64'h1);
    issue(8, 0, 7, 0, 0, 0, 0, 64'hFFFF, 64'h0);
    issue(8, 1, 12, 0, 0, 0, 0, 64'hFFFF, 64'h0);
    issue(8, 1, 15, 0, 0, 0, 0, 64'hFFFF, 64'h0);
    issue(9, 1, 6, 0, 0, 0, 0, 64'h1, 64'h2);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 idle valid", {63'd0, res_valid}, 64'd0);
    check("R1 queue drained", 64'(sb.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule